// File: doc/BRIEF.md
# Completion Counter with Coalesced Interrupt

This block keeps a running total of completed work for one output port and decides when software should be interrupted. Each time the port sends a packet, the total grows by one, or by the packet's byte length when byte accounting is selected. Software acknowledges what it has processed by writing an amount that is taken off the total, so completions that arrive while software is busy are never lost.

Interrupts are coalesced by two limits. The first is a count limit. The second is an age limit, measured by a coarse timer that advances once every `PRESC` clock cycles, and only while the total is non-zero. The interrupt level is high while either limit is strictly exceeded. A one-cycle pulse marks each rising edge of that level. Software can also ask for the pulse again through a write-1 resend bit.

The block has a two-register read/write port, a sent-packet input, a level output and a pulse output.

Top module: `cmpl_coalesce`

## Requirements
- R1: After synchronous reset, count, age timer, prescaler, both limits and the byte-mode bit are zero, and `irq_level` and `irq_pulse` are low.
- R2: On a cycle with `sent_valid` high, the count grows by 1 when the byte-mode bit (bit 63 of the limit register) is 0. It grows by `sent_bytes` when that bit is 1.
- R3: A write with `reg_sel`=0 subtracts `reg_wdata[CNT_W-1:0]` from the count. It never overwrites the count. If an increment lands in the same cycle, the new count is count + increment - written value. A result below zero clamps to zero.
- R4: The count saturates at its all-ones value and never wraps.
- R5: While the count is non-zero, the age timer advances by one every `PRESC` cycles. The first advance comes `PRESC` cycles after the count leaves zero. The timer saturates at its all-ones value.
- R6: In the same cycle that the count becomes zero, the age timer and the prescaler are cleared, and `irq_level` is low.
- R7: `irq_level` is high exactly when count > count limit or timer > age limit. Both comparisons are strict. `irq_level` also reads back as bit 63 of the count register.
- R8: `irq_pulse` is high for one cycle, in the cycle after `irq_level` rises.
- R9: A write with `reg_sel`=0 and `reg_wdata[60]`=1 produces an `irq_pulse` in the next cycle if `irq_level` is high. If `irq_level` is low, it produces none. The count field of the same write is still subtracted.
- R10: A write with `reg_sel`=1 replaces the settings. The count limit is in `[CNT_W-1:0]`, the age limit is in `[32+TMR_W-1:32]` and the byte-mode bit is bit 63. Reads with `reg_sel`=1 return the settings in this layout. Reads with `reg_sel`=0 return the count in `[CNT_W-1:0]`, the timer in `[32+TMR_W-1:32]`, the level in bit 63, and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sent_valid | input | 1 | One packet left the port this cycle |
| sent_bytes | input | BYTE_W | Byte length of that packet |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = count register, 1 = limit register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| irq_level | output | 1 | Coalesced interrupt level |
| irq_pulse | output | 1 | One-cycle interrupt event |

## Verification
The hardware increment and the software subtract can fall in the same clock edge. So can a count that hits zero and a pending timer tick. The bench provokes these cases by holding `sent_valid` high through an acknowledge write, and by subtracting the whole count on a cycle when a packet also arrives. A behavioural model applies the increment, the subtract and the clamps on every edge. Its count, timer, level and pulse are compared with the read port and with the outputs after every clock.

// File: rtl/ccnt_pkg.sv
`timescale 1ns/1ps
package ccnt_pkg;

    localparam int REG_W      = 64;
    localparam int TMR_LSB    = 32;
    localparam int FLAG_BIT   = 63;
    localparam int MODE_BIT   = 63;
    localparam int RESEND_BIT = 60;

    typedef enum logic {
        SEL_COUNT  = 1'b0,
        SEL_LIMITS = 1'b1
    } reg_sel_e;

    typedef enum logic {
        ACC_PACKETS = 1'b0,
        ACC_BYTES   = 1'b1
    } acc_mode_e;

    // Add, then subtract with a floor at zero, then cap at max.
    function automatic logic [63:0] add_sub_clamp(
        input logic [63:0] cur,
        input logic [63:0] inc,
        input logic [63:0] sub,
        input logic [63:0] max
    );
        logic [63:0] sum;
        logic [63:0] dif;
        sum = cur + inc;
        if (sum < sub) dif = 64'd0;
        else           dif = sum - sub;
        if (dif > max) dif = max;
        return dif;
    endfunction

endpackage

// File: rtl/ccnt_count_path.sv
`timescale 1ns/1ps
module ccnt_count_path #(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  add_en,
    input  ccnt_pkg::acc_mode_e   mode,
    input  logic [BYTE_W-1:0]     add_bytes,
    input  logic                  sub_en,
    input  logic [CNT_W-1:0]      sub_val,
    output logic [CNT_W-1:0]      cnt_q,
    output logic [CNT_W-1:0]      cnt_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [63:0] inc64;
    logic [63:0] sub64;

    always_comb begin
        if (!add_en)                           inc64 = 64'd0;
        else if (mode == ccnt_pkg::ACC_BYTES)  inc64 = 64'(add_bytes);
        else                                   inc64 = 64'd1;
        sub64    = sub_en ? 64'(sub_val) : 64'd0;
        cnt_next = CNT_W'(ccnt_pkg::add_sub_clamp(64'(cnt_q), inc64, sub64, 64'(CNT_MAX)));
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_next;
    end
endmodule

// File: rtl/ccnt_age_timer.sv
`timescale 1ns/1ps
module ccnt_age_timer #(
    parameter int TMR_W = 22,
    parameter int PRESC = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             idle_next,
    output logic [TMR_W-1:0] tmr_q
);
    localparam int               PRE_W    = (PRESC > 2) ? $clog2(PRESC) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESC - 1);
    localparam logic [TMR_W-1:0] TMR_MAX  = '1;

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || idle_next) begin
            pre_q <= '0;
            tmr_q <= '0;
        end else if (busy) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (tmr_q != TMR_MAX) tmr_q <= tmr_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccnt_irq_gen.sv
`timescale 1ns/1ps
module ccnt_irq_gen #(
    parameter int CNT_W = 32,
    parameter int TMR_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [TMR_W-1:0] tmr,
    input  logic [CNT_W-1:0] cnt_lim,
    input  logic [TMR_W-1:0] tmr_lim,
    input  logic             resend_req,
    output logic             level,
    output logic             pulse
);
    logic level_prev_q;

    always_comb level = (cnt > cnt_lim) || (tmr > tmr_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_prev_q <= 1'b0;
            pulse        <= 1'b0;
        end else begin
            level_prev_q <= level;
            pulse        <= (level && !level_prev_q) || (resend_req && level);
        end
    end
endmodule

// File: rtl/cmpl_coalesce.sv
`timescale 1ns/1ps
module cmpl_coalesce #(
    parameter int CNT_W  = 32,
    parameter int TMR_W  = 22,
    parameter int PRESC  = 2048,
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sent_valid,
    input  logic [BYTE_W-1:0] sent_bytes,
    input  logic              reg_wen,
    input  logic              reg_sel,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              irq_level,
    output logic              irq_pulse
);
    import ccnt_pkg::*;

    reg_sel_e          sel;
    logic              wr_count;
    logic              wr_limits;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_next;
    logic [TMR_W-1:0]  tmr_q;
    logic [CNT_W-1:0]  cnt_lim_q;
    logic [TMR_W-1:0]  tmr_lim_q;
    acc_mode_e         mode_q;

    always_comb begin
        sel       = reg_sel_e'(reg_sel);
        wr_count  = reg_wen && (sel == SEL_COUNT);
        wr_limits = reg_wen && (sel == SEL_LIMITS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lim_q <= '0;
            tmr_lim_q <= '0;
            mode_q    <= ACC_PACKETS;
        end else if (wr_limits) begin
            cnt_lim_q <= reg_wdata[CNT_W-1:0];
            tmr_lim_q <= reg_wdata[TMR_LSB +: TMR_W];
            mode_q    <= acc_mode_e'(reg_wdata[MODE_BIT]);
        end
    end

    ccnt_count_path #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .add_en    (sent_valid),
        .mode      (mode_q),
        .add_bytes (sent_bytes),
        .sub_en    (wr_count),
        .sub_val   (reg_wdata[CNT_W-1:0]),
        .cnt_q     (cnt_q),
        .cnt_next  (cnt_next)
    );

    ccnt_age_timer #(.TMR_W(TMR_W), .PRESC(PRESC)) u_age (
        .clk       (clk),
        .rst       (rst),
        .busy      (cnt_q != '0),
        .idle_next (cnt_next == '0),
        .tmr_q     (tmr_q)
    );

    ccnt_irq_gen #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .cnt        (cnt_q),
        .tmr        (tmr_q),
        .cnt_lim    (cnt_lim_q),
        .tmr_lim    (tmr_lim_q),
        .resend_req (wr_count && reg_wdata[RESEND_BIT]),
        .level      (irq_level),
        .pulse      (irq_pulse)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel == SEL_LIMITS) begin
            reg_rdata[CNT_W-1:0]         = cnt_lim_q;
            reg_rdata[TMR_LSB +: TMR_W]  = tmr_lim_q;
            reg_rdata[MODE_BIT]          = (mode_q == ACC_BYTES);
        end else begin
            reg_rdata[CNT_W-1:0]         = cnt_q;
            reg_rdata[TMR_LSB +: TMR_W]  = tmr_q;
            reg_rdata[FLAG_BIT]          = irq_level;
        end
    end
endmodule

// File: rtl/ccnt_checker.sv
`timescale 1ns/1ps
module ccnt_checker #(
    parameter int CNT_W = 32,
    parameter int TMR_W = 22
) (
    input logic             clk,
    input logic             rst,
    input logic             sent_valid,
    input logic             reg_wen,
    input logic             reg_sel,
    input logic [63:0]      reg_wdata,
    input logic             irq_level,
    input logic             irq_pulse,
    input logic [CNT_W-1:0] cnt,
    input logic [TMR_W-1:0] tmr,
    input logic             byte_mode
);
    p_incr_r2: assert property (@(posedge clk) disable iff (rst)
        (sent_valid && !byte_mode && !reg_wen && cnt != {CNT_W{1'b1}})
        |=> (cnt == $past(cnt) + 1'b1));

    p_sub_clamp_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && !reg_sel && !sent_valid && reg_wdata[CNT_W-1:0] >= cnt)
        |=> (cnt == '0));

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt == {CNT_W{1'b1}} && !reg_wen) |=> (cnt == {CNT_W{1'b1}}));

    p_tmr_step_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(tmr) |-> (tmr == $past(tmr) + 1'b1 || tmr == '0));

    p_idle_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> (tmr == '0 && !irq_level));

    p_pulse_src_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(irq_level));

    p_rise_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_level) |=> irq_pulse);
endmodule

bind cmpl_coalesce ccnt_checker #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sent_valid (sent_valid),
    .reg_wen    (reg_wen),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .irq_level  (irq_level),
    .irq_pulse  (irq_pulse),
    .cnt        (cnt_q),
    .tmr        (tmr_q),
    .byte_mode  (mode_q == ccnt_pkg::ACC_BYTES)
);

// File: tb/cmpl_coalesce_tb_top.sv
`timescale 1ns/1ps
module cmpl_coalesce_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW    = 16;
    localparam int TW    = 6;
    localparam int PS    = 16;
    localparam int BW    = 16;
    localparam longint CMAX = (64'd1 << CW) - 1;
    localparam longint TMAX = (64'd1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sent_valid = 1'b0;
    logic [BW-1:0] sent_bytes = '0;
    logic          reg_wen = 1'b0;
    logic          reg_sel = 1'b0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic          irq_level;
    logic          irq_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string phase = "R1";

    longint m_cnt, m_tmr, m_pre, m_cthr, m_tthr;
    bit     m_bmode, m_fprev, m_pulse;

    cmpl_coalesce #(.CNT_W(CW), .TMR_W(TW), .PRESC(PS), .BYTE_W(BW)) dut_i (
        .clk(clk), .rst(rst), .sent_valid(sent_valid), .sent_bytes(sent_bytes),
        .reg_wen(reg_wen), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_level(irq_level), .irq_pulse(irq_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_flag();
        return (m_cnt > m_cthr) || (m_tmr > m_tthr);
    endfunction

    function automatic logic [63:0] m_rdata(input logic sel);
        logic [63:0] v;
        v = '0;
        if (sel) begin
            v[CW-1:0] = m_cthr[CW-1:0]; v[32 +: TW] = m_tthr[TW-1:0]; v[63] = m_bmode;
        end else begin
            v[CW-1:0] = m_cnt[CW-1:0];  v[32 +: TW] = m_tmr[TW-1:0];  v[63] = m_flag();
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Reference model: behaviour from the requirements, one update per edge.
    always @(posedge clk) begin
        longint inc, sub, nc;
        bit fl;
        if (rst) begin
            m_cnt = 0; m_tmr = 0; m_pre = 0; m_cthr = 0; m_tthr = 0;
            m_bmode = 0; m_fprev = 0; m_pulse = 0;
        end else begin
            fl  = m_flag();
            inc = sent_valid ? (m_bmode ? longint'(sent_bytes) : 1) : 0;
            sub = (reg_wen && !reg_sel) ? longint'(reg_wdata[CW-1:0]) : 0;
            nc  = m_cnt + inc - sub;
            if (nc < 0) nc = 0;
            if (nc > CMAX) nc = CMAX;
            if (nc == 0) begin
                m_tmr = 0; m_pre = 0;
            end else if (m_cnt != 0) begin
                if (m_pre == PS - 1) begin
                    m_pre = 0;
                    if (m_tmr < TMAX) m_tmr = m_tmr + 1;
                end else m_pre = m_pre + 1;
            end
            m_pulse = (fl && !m_fprev) || (reg_wen && !reg_sel && reg_wdata[60] && fl);
            m_fprev = fl;
            if (reg_wen && reg_sel) begin
                m_cthr = longint'(reg_wdata[CW-1:0]);
                m_tthr = longint'(reg_wdata[32 +: TW]);
                m_bmode = reg_wdata[63];
            end
            m_cnt = nc;
        end
    end

    // Per-cycle comparison, one time unit after the edge.
    always @(posedge clk) begin
        #1;
        cycles++;
        if (!rst) begin
            check({phase, " rdata"}, reg_rdata, m_rdata(reg_sel));
            check({phase, " level"}, 64'(irq_level), 64'(m_flag()));
            check({phase, " pulse"}, 64'(irq_pulse), 64'(m_pulse));
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [63:0] d);
        reg_wen = 1'b1; reg_sel = sel; reg_wdata = d;
        step(1);
        reg_wen = 1'b0; reg_wdata = '0; reg_sel = 1'b0;
    endtask

    task automatic send(input int n, input int bytes);
        sent_valid = 1'b1; sent_bytes = BW'(bytes);
        step(n);
        sent_valid = 1'b0; sent_bytes = '0;
    endtask

    function automatic logic [63:0] lim(input int c, input int t, input bit b);
        logic [63:0] v;
        v = '0; v[CW-1:0] = CW'(c); v[32 +: TW] = TW'(t); v[63] = b;
        return v;
    endfunction

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1: reset state through both registers and outputs
        reg_sel = 1'b0; #1; check("R1 count reg", reg_rdata, 64'd0);
        reg_sel = 1'b1; #1; check("R1 limit reg", reg_rdata, 64'd0);
        check("R1 irq", {62'd0, irq_level, irq_pulse}, 64'd0);
        reg_sel = 1'b0;

        // R10: limits written and read back; large age limit first
        phase = "R10";
        wr(1'b1, lim(7, 40, 1'b0));
        reg_sel = 1'b1; #1; check("R10 readback", reg_rdata, lim(7, 40, 1'b0)); reg_sel = 1'b0;

        // R2: packet counting
        phase = "R2";
        send(5, 999);
        #1; check("R2 packet count", 64'(reg_rdata[CW-1:0]), 64'd5);

        // R7/R8: count crosses limit strictly
        phase = "R7";
        send(2, 0);
        #1; check("R7 equal no irq", 64'(irq_level), 64'd0);
        phase = "R8";
        send(1, 0);
        step(2);
        #1; check("R7 above limit", 64'(irq_level), 64'd1);

        // R3: subtract, and subtract with concurrent increments
        phase = "R3";
        wr(1'b0, 64'd3);
        #1; check("R3 subtract", 64'(reg_rdata[CW-1:0]), 64'd5);
        sent_valid = 1'b1;
        wr(1'b0, 64'd2);
        sent_valid = 1'b0;
        #1; check("R3 concurrent", 64'(reg_rdata[CW-1:0]), 64'd4);

        // R5: timer ticks while busy
        phase = "R5";
        step(3 * PS);
        // R6: clamp-to-zero subtract clears timer and level
        phase = "R6";
        sent_valid = 1'b1;
        wr(1'b0, 64'd100);
        sent_valid = 1'b0;
        #1; check("R6 cleared", reg_rdata, 64'd0);

        // R5: age limit path and timer saturation
        phase = "R5";
        wr(1'b1, lim(1000, 2, 1'b0));
        send(1, 0);
        step(PS * (TMAX + 4));
        #1; check("R5 timer saturates", 64'(reg_rdata[32 +: TW]), 64'(TMAX));

        // R9: resend while high, then while low
        phase = "R9";
        wr(1'b0, 64'h1000_0000_0000_0000);
        step(1);
        wr(1'b1, lim(1000, TMAX, 1'b0));
        step(2);
        wr(1'b0, 64'h1000_0000_0000_0000);
        #1; check("R9 no pulse when low", 64'(irq_pulse), 64'd0);
        wr(1'b0, 64'd1);

        // R4: byte mode and saturation
        phase = "R4";
        wr(1'b1, lim(50000, TMAX, 1'b1));
        send(1, 300);
        #1; check("R2 byte count", 64'(reg_rdata[CW-1:0]), 64'd300);
        send(3, 40000);
        #1; check("R4 saturated", 64'(reg_rdata[CW-1:0]), 64'(CMAX));
        wr(1'b0, 64'(CMAX) | 64'h1000_0000_0000_0000);
        step(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule